// File: doc/BRIEF.md
# Transmit Equalizer Settings Validator

This block screens a candidate set of transmit equalizer settings before they are written to a serial transmitter. A set has five parts: a main-tap drive code, pre-tap and post-tap magnitude codes, a pre-tap polarity bit, and three switch-enable fields, one for each tap. The block converts the codes to tap currents in integer units of 0.2 mA. A main code step is 10 units (2 mA). A pre-tap or post-tap code step is 1 unit.

Three current-budget rules are applied to these currents: a ceiling on the total, a floor on the eye-opening margin, and a limit on the ratio of largest to smallest swing. The ratio limit is tested without division. The block also checks that each switch field is a legal thermometer pattern and that enough side-tap switches are enabled for the codes. Software or a tuning engine raises a request strobe with the settings on the inputs. One cycle later it reads a pass flag and a vector with one violation bit per rule.

Top module: `eqv_validator`

## Requirements
- R1: A request strobe sampled at a clock edge makes `res_valid` high for exactly the following cycle. `res_pass` and `res_viol` are registered at that edge and keep their values until the next request, whatever the inputs do in between.
- R2: While `rst` is high, `res_valid`, `res_pass` and `res_viol` are all zero.
- R3: `res_viol[0]` (total) is set when pre + 10·main + post exceeds 60 units.
- R4: `res_viol[1]` (margin) is set when 10·main − pre − post is below 9 units.
- R5: `res_viol[2]` (ratio) is set when the margin is zero or negative, or when the total is at least 7 times the margin.
- R6: `res_viol[3]` (range) is set when the main code is 6 or 7. The current rules still use that code as given.
- R7: `res_viol[4]` (encoding) is set when a switch field is not a thermometer pattern. The legal side-tap fields are 00, 01 and 11. The legal main fields are 0000, 0001, 0011, 0111 and 1111.
- R8: `res_viol[5]` (switch count) is set when a side-tap field has no ones. It is also set when the side-tap code is 11 or more and the field has fewer than two ones. The count is the number of ones, even in an illegal pattern.
- R9: `res_pass` is 1 exactly when all six violation bits are 0.
- R10: `cfg_pre_inv` has no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe; settings are sampled when high |
| cfg_main | input | 3 | Main-tap drive code |
| cfg_pre | input | 4 | Pre-tap magnitude code |
| cfg_post | input | 5 | Post-tap magnitude code |
| cfg_pre_inv | input | 1 | Pre-tap polarity (ignored by all rules) |
| cfg_main_sw | input | 4 | Main-tap switch-enable field |
| cfg_pre_sw | input | 2 | Pre-tap switch-enable field |
| cfg_post_sw | input | 2 | Post-tap switch-enable field |
| res_valid | output | 1 | Result strobe, one cycle after a request |
| res_pass | output | 1 | All rules met |
| res_viol | output | 6 | Violation bits: 0 total, 1 margin, 2 ratio, 3 range, 4 encoding, 5 switch count |

## Verification
The vector table places each current rule on both sides of its limit:
- For the total, the sums 60 and 61.
- For the margin, the margins 9 and 8.
- For the ratio, a total of 87 against a margin of 13, and 88 against 12.

These pairs separate an off-by-one comparison from a correct one. The table also includes a zero-current set, where the margin and ratio rules must both fire. It includes two known settings, one that passes and one that fails only on margin. Switch patterns cover:
- legal and illegal thermometer codes for each tap;
- the code-10 and code-11 switch threshold;
- an illegal field that also has too few switches.

These patterns show that encoding and count are judged apart. Repeating vectors with the polarity bit set shows it is ignored. Directed tests cover the hold of results between requests and a reset after a result.

// File: rtl/eqv_pkg.sv
package eqv_pkg;

    localparam int VIOL_W   = 6;
    localparam int V_SUM    = 0;
    localparam int V_MARGIN = 1;
    localparam int V_RATIO  = 2;
    localparam int V_RANGE  = 3;
    localparam int V_ENC    = 4;
    localparam int V_COUNT  = 5;

    // Flags from the current-budget rules
    typedef struct packed {
        logic ratio;
        logic margin;
        logic sum;
    } budget_flags_t;

    // Flags from the switch-field rules
    typedef struct packed {
        logic count;
        logic enc;
    } switch_flags_t;

    // A field is a thermometer code when it is of the form 0..01..1
    function automatic logic thermo_ok(input logic [7:0] f);
        return ((f & (f + 8'd1)) == 8'd0);
    endfunction

    function automatic logic [3:0] ones8(input logic [7:0] f);
        logic [3:0] n;
        n = 4'd0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'd0, f[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/eqv_current_budget.sv
module eqv_current_budget
    import eqv_pkg::*;
#(
    parameter int PRE_W      = 4,
    parameter int POST_W     = 5,
    parameter int MAIN_W     = 3,
    parameter int MAIN_STEP  = 10,
    parameter int SUM_LIMIT  = 60,
    parameter int MARGIN_MIN = 9,
    parameter int RATIO_K    = 7
) (
    input  logic [MAIN_W-1:0] main_code,
    input  logic [PRE_W-1:0]  pre_code,
    input  logic [POST_W-1:0] post_code,
    output budget_flags_t     flags
);
    localparam int ACC_W  = 12;
    localparam int WIDE_W = 2 * ACC_W;

    logic [ACC_W-1:0]         pre_u, post_u, main_u, sum_u;
    logic signed [ACC_W-1:0]  margin_s;
    logic signed [WIDE_W-1:0] margin_scaled;
    logic signed [WIDE_W-1:0] sum_wide;

    // All currents are counted in units of the side-tap step
    assign pre_u    = ACC_W'(pre_code);
    assign post_u   = ACC_W'(post_code);
    assign main_u   = ACC_W'(main_code) * ACC_W'(MAIN_STEP);
    assign sum_u    = pre_u + main_u + post_u;
    assign margin_s = $signed(main_u) - $signed(pre_u) - $signed(post_u);

    // The ratio limit (max/min - 1 < K-1) becomes sum < K * margin
    assign margin_scaled = WIDE_W'(margin_s) * WIDE_W'(RATIO_K);
    assign sum_wide      = $signed({{ACC_W{1'b0}}, sum_u});

    always_comb begin
        flags.sum    = (sum_u > ACC_W'(SUM_LIMIT));
        flags.margin = (margin_s < $signed(ACC_W'(MARGIN_MIN)));
        flags.ratio  = (margin_s <= $signed(ACC_W'(0))) || (sum_wide >= margin_scaled);
    end

endmodule

// File: rtl/eqv_switch_check.sv
module eqv_switch_check
    import eqv_pkg::*;
#(
    parameter int PRE_W     = 4,
    parameter int POST_W    = 5,
    parameter int SIDE_SW_W = 2,
    parameter int MAIN_SW_W = 4,
    parameter int SW_THRESH = 10
) (
    input  logic [PRE_W-1:0]     pre_code,
    input  logic [POST_W-1:0]    post_code,
    input  logic [SIDE_SW_W-1:0] pre_sw,
    input  logic [SIDE_SW_W-1:0] post_sw,
    input  logic [MAIN_SW_W-1:0] main_sw,
    output switch_flags_t        flags
);
    localparam int CODE_W = (PRE_W > POST_W) ? PRE_W : POST_W;
    localparam int N_SIDE = 2;

    logic [CODE_W-1:0]    side_code [N_SIDE];
    logic [SIDE_SW_W-1:0] side_sw   [N_SIDE];
    logic [N_SIDE-1:0]    side_bad_enc;
    logic [N_SIDE-1:0]    side_short;
    logic                 main_bad_enc;

    assign side_code[0] = CODE_W'(pre_code);
    assign side_code[1] = CODE_W'(post_code);
    assign side_sw[0]   = pre_sw;
    assign side_sw[1]   = post_sw;

    for (genvar g = 0; g < N_SIDE; g++) begin : g_side
        logic [3:0] on_cnt;
        logic       need_two;
        assign on_cnt          = ones8(8'(side_sw[g]));
        assign need_two        = (side_code[g] > CODE_W'(SW_THRESH));
        assign side_bad_enc[g] = !thermo_ok(8'(side_sw[g]));
        assign side_short[g]   = (on_cnt == 4'd0) || (need_two && (on_cnt < 4'd2));
    end

    assign main_bad_enc = !thermo_ok(8'(main_sw));

    always_comb begin
        flags.enc   = main_bad_enc || (|side_bad_enc);
        flags.count = |side_short;
    end

endmodule

// File: rtl/eqv_validator.sv
module eqv_validator
    import eqv_pkg::*;
#(
    parameter int PRE_W      = 4,
    parameter int POST_W     = 5,
    parameter int MAIN_W     = 3,
    parameter int MAIN_MAX   = 5,
    parameter int MAIN_STEP  = 10,
    parameter int SUM_LIMIT  = 60,
    parameter int MARGIN_MIN = 9,
    parameter int RATIO_K    = 7,
    parameter int SIDE_SW_W  = 2,
    parameter int MAIN_SW_W  = 4,
    parameter int SW_THRESH  = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic [MAIN_W-1:0]    cfg_main,
    input  logic [PRE_W-1:0]     cfg_pre,
    input  logic [POST_W-1:0]    cfg_post,
    input  logic                 cfg_pre_inv,
    input  logic [MAIN_SW_W-1:0] cfg_main_sw,
    input  logic [SIDE_SW_W-1:0] cfg_pre_sw,
    input  logic [SIDE_SW_W-1:0] cfg_post_sw,
    output logic                 res_valid,
    output logic                 res_pass,
    output logic [VIOL_W-1:0]    res_viol
);
    budget_flags_t     bud;
    switch_flags_t     swf;
    logic              range_bad;
    logic [VIOL_W-1:0] viol_next;
    logic              unused_inv;

    // Polarity plays no part in any rule
    assign unused_inv = cfg_pre_inv;

    eqv_current_budget #(
        .PRE_W(PRE_W), .POST_W(POST_W), .MAIN_W(MAIN_W),
        .MAIN_STEP(MAIN_STEP), .SUM_LIMIT(SUM_LIMIT),
        .MARGIN_MIN(MARGIN_MIN), .RATIO_K(RATIO_K)
    ) u_budget (
        .main_code(cfg_main), .pre_code(cfg_pre), .post_code(cfg_post),
        .flags(bud)
    );

    eqv_switch_check #(
        .PRE_W(PRE_W), .POST_W(POST_W), .SIDE_SW_W(SIDE_SW_W),
        .MAIN_SW_W(MAIN_SW_W), .SW_THRESH(SW_THRESH)
    ) u_switch (
        .pre_code(cfg_pre), .post_code(cfg_post),
        .pre_sw(cfg_pre_sw), .post_sw(cfg_post_sw), .main_sw(cfg_main_sw),
        .flags(swf)
    );

    assign range_bad = (cfg_main > MAIN_W'(MAIN_MAX));

    always_comb begin
        viol_next           = '0;
        viol_next[V_SUM]    = bud.sum;
        viol_next[V_MARGIN] = bud.margin;
        viol_next[V_RATIO]  = bud.ratio;
        viol_next[V_RANGE]  = range_bad;
        viol_next[V_ENC]    = swf.enc;
        viol_next[V_COUNT]  = swf.count;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_pass  <= 1'b0;
            res_viol  <= '0;
        end else begin
            res_valid <= req;
            if (req) begin
                res_viol <= viol_next;
                res_pass <= (viol_next == '0);
            end
        end
    end

endmodule

// File: rtl/eqv_validator_chk.sv
module eqv_validator_chk
    import eqv_pkg::*;
#(
    parameter int MAIN_W    = 3,
    parameter int MAIN_MAX  = 5,
    parameter int SIDE_SW_W = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req,
    input logic [MAIN_W-1:0]    cfg_main,
    input logic [SIDE_SW_W-1:0] cfg_pre_sw,
    input logic                 res_valid,
    input logic                 res_pass,
    input logic [VIOL_W-1:0]    res_viol
);
    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req |=> res_valid);                                                    // R1
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req |=> !res_valid);                                                  // R1
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !req |=> ($stable(res_viol) && $stable(res_pass)));                    // R1
    AST_MAIN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (req && (cfg_main > MAIN_W'(MAIN_MAX))) |=> res_viol[V_RANGE]);        // R6
    AST_PRE_SW_ENC: assert property (@(posedge clk) disable iff (rst)
        (req && (cfg_pre_sw == 2'b10)) |=> res_viol[V_ENC]);                   // R7
    AST_PASS_AGREES: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_pass == (res_viol == '0)));                         // R9
endmodule

bind eqv_validator eqv_validator_chk #(
    .MAIN_W(MAIN_W), .MAIN_MAX(MAIN_MAX), .SIDE_SW_W(SIDE_SW_W)
) u_chk (
    .clk(clk), .rst(rst), .req(req), .cfg_main(cfg_main),
    .cfg_pre_sw(cfg_pre_sw), .res_valid(res_valid),
    .res_pass(res_pass), .res_viol(res_viol)
);

// File: tb/eqv_validator_test.sv
module eqv_validator_test;

    typedef struct packed {
        logic [2:0] main_c;
        logic [3:0] pre_c;
        logic [4:0] post_c;
        logic       inv;
        logic [3:0] msw;
        logic [1:0] psw;
        logic [1:0] qsw;
        logic [5:0] exp_viol;
    } vec_t;

    localparam int NV = 23;
    // exp_viol bits: 0 total, 1 margin, 2 ratio, 3 range, 4 encoding, 5 count
    localparam vec_t VECS [NV] = '{
        {3'd3, 4'd0,  5'd5,  1'b0, 4'b0011, 2'b01, 2'b01, 6'b000000}, // R9 default passes
        {3'd2, 4'd5,  5'd8,  1'b0, 4'b0011, 2'b01, 2'b01, 6'b000010}, // R4 margin 7
        {3'd5, 4'd15, 5'd31, 1'b0, 4'b0011, 2'b11, 2'b11, 6'b000111}, // R3 R4 R5
        {3'd5, 4'd5,  5'd5,  1'b0, 4'b0011, 2'b01, 2'b01, 6'b000000}, // R3 total 60
        {3'd5, 4'd5,  5'd6,  1'b0, 4'b0011, 2'b01, 2'b01, 6'b000001}, // R3 total 61
        {3'd1, 4'd1,  5'd0,  1'b0, 4'b0011, 2'b01, 2'b01, 6'b000000}, // R4 margin 9
        {3'd1, 4'd2,  5'd0,  1'b0, 4'b0011, 2'b01, 2'b01, 6'b000010}, // R4 margin 8
        {3'd5, 4'd15, 5'd23, 1'b0, 4'b0011, 2'b11, 2'b11, 6'b000101}, // R5 88 vs 84
        {3'd5, 4'd15, 5'd22, 1'b0, 4'b0011, 2'b11, 2'b11, 6'b000001}, // R5 87 vs 91
        {3'd6, 4'd0,  5'd0,  1'b0, 4'b0011, 2'b01, 2'b01, 6'b001000}, // R6 code 6
        {3'd7, 4'd0,  5'd0,  1'b0, 4'b0011, 2'b01, 2'b01, 6'b001001}, // R6 code 7
        {3'd3, 4'd0,  5'd5,  1'b0, 4'b0011, 2'b10, 2'b01, 6'b010000}, // R7 pre 10
        {3'd3, 4'd0,  5'd5,  1'b0, 4'b0101, 2'b01, 2'b01, 6'b010000}, // R7 main 0101
        {3'd3, 4'd0,  5'd5,  1'b0, 4'b1111, 2'b01, 2'b01, 6'b000000}, // R7 main 1111
        {3'd3, 4'd0,  5'd5,  1'b0, 4'b0000, 2'b01, 2'b01, 6'b000000}, // R7 main 0000
        {3'd3, 4'd11, 5'd5,  1'b0, 4'b0011, 2'b01, 2'b01, 6'b100000}, // R8 code 11 one sw
        {3'd3, 4'd10, 5'd5,  1'b0, 4'b0011, 2'b01, 2'b01, 6'b000000}, // R8 code 10 one sw
        {3'd3, 4'd0,  5'd0,  1'b0, 4'b0011, 2'b01, 2'b00, 6'b100000}, // R8 no post sw
        {3'd5, 4'd0,  5'd31, 1'b0, 4'b0011, 2'b01, 2'b11, 6'b000001}, // R8 post 31 two sw
        {3'd3, 4'd0,  5'd5,  1'b1, 4'b0011, 2'b01, 2'b01, 6'b000000}, // R10 inv default
        {3'd2, 4'd5,  5'd8,  1'b1, 4'b0011, 2'b01, 2'b01, 6'b000010}, // R10 inv margin
        {3'd0, 4'd0,  5'd0,  1'b0, 4'b0011, 2'b01, 2'b01, 6'b000110}, // R5 zero margin
        {3'd3, 4'd0,  5'd11, 1'b0, 4'b0011, 2'b01, 2'b10, 6'b110000}  // R7 R8 post 10
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic [2:0] cfg_main = '0;
    logic [3:0] cfg_pre = '0;
    logic [4:0] cfg_post = '0;
    logic       cfg_pre_inv = 1'b0;
    logic [3:0] cfg_main_sw = '0;
    logic [1:0] cfg_pre_sw = '0;
    logic [1:0] cfg_post_sw = '0;
    logic       res_valid, res_pass;
    logic [5:0] res_viol;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    eqv_validator uut (
        .clk(clk), .rst(rst), .req(req), .cfg_main(cfg_main), .cfg_pre(cfg_pre),
        .cfg_post(cfg_post), .cfg_pre_inv(cfg_pre_inv), .cfg_main_sw(cfg_main_sw),
        .cfg_pre_sw(cfg_pre_sw), .cfg_post_sw(cfg_post_sw),
        .res_valid(res_valid), .res_pass(res_pass), .res_viol(res_viol)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic drive(input vec_t v);
        cfg_main    = v.main_c;
        cfg_pre     = v.pre_c;
        cfg_post    = v.post_c;
        cfg_pre_inv = v.inv;
        cfg_main_sw = v.msw;
        cfg_pre_sw  = v.psw;
        cfg_post_sw = v.qsw;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: reset state
        chk(res_valid == 1'b0, "R2 valid in reset", int'(res_valid), 0);
        chk(res_pass == 1'b0, "R2 pass in reset", int'(res_pass), 0);
        chk(res_viol == 6'd0, "R2 viol in reset", int'(res_viol), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(res_valid == 1'b0, "R1 no request no valid", int'(res_valid), 0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            chk(res_valid == 1'b1, $sformatf("R1 valid vec %0d", i), int'(res_valid), 1);
            chk(res_viol == VECS[i].exp_viol, $sformatf("R3-set viol vec %0d", i),
                int'(res_viol), int'(VECS[i].exp_viol));
            chk(res_pass == (VECS[i].exp_viol == 6'd0), $sformatf("R9 pass vec %0d", i),
                int'(res_pass), int'(VECS[i].exp_viol == 6'd0));
        end

        // R1: results hold while inputs change without a request
        drive(VECS[1]);
        @(negedge clk);
        chk(res_valid == 1'b0, "R1 valid drops", int'(res_valid), 0);
        chk(res_viol == 6'b110000, "R1 viol held", int'(res_viol), 48);
        chk(res_pass == 1'b0, "R1 pass held", int'(res_pass), 0);

        // R1: back-to-back requests give valid on consecutive cycles
        drive(VECS[0]);
        req = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b1 && res_pass == 1'b1, "R1 first of pair", int'(res_pass), 1);
        drive(VECS[1]);
        @(negedge clk);
        req = 1'b0;
        chk(res_valid == 1'b1 && res_viol == 6'b000010, "R1 second of pair", int'(res_viol), 2);

        // R2: reset after a result clears outputs
        drive(VECS[0]);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0 && res_pass == 1'b0, "R2 reset clears", int'(res_pass), 0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule